// File: doc/BRIEF.md
# Output Power-Good Supervisor

This block decides whether a regulated output is good and drives both a status bit and an external flag pin from that decision. It watches digitized output-voltage samples and compares each valid sample against two levels. Both levels are percentages of a nominal voltage, and the level for the good state sits above the level for the bad state. A valid sample strictly above the upper level makes the level good. A valid sample strictly below the lower level makes it bad. Samples between the two levels leave the level where it was.

The output is declared good only after every condition has held without a break: the level is good and no fault is reported. There are two ways to qualify it. In the normal way, a delay counter advances on an external slow tick, typically one tick per millisecond, until it reaches a programmed count. In the other way, used when automatic loop tuning is enabled, the delay is skipped and the output goes good on the cycle after the tuning-complete pulse. Any loss of a condition drops the flag at once and clears the delay count.

The flag pin is active high. It can be encoded for an open-drain driver, which is the reset mode, or for a push-pull driver. The threshold percentages, the nominal value and the delay count are supplied by registers outside the block.

Top module: `pwrok_supervisor`

## Requirements
- R1: After reset, `pwr_ok_o` is 0 and the pin is in open-drain not-good encoding (`pin_oe_o`=1, `pin_dat_o`=0).
- R2: The level becomes good only when `smp_vld_i`=1 and `smp_val_i` > floor(`nom_i`*`rise_pct_i`/100). A sample equal to that value, or any sample with `smp_vld_i`=0, does not raise the level.
- R3: The level becomes bad only when `smp_vld_i`=1 and `smp_val_i` < floor(`nom_i`*`fall_pct_i`/100). A sample between the two levels holds the current state, whether good or bad.
- R4: With `tune_en_i`=0, once the level is good and `fault_i`=0, `tick_i` pulses are counted. `pwr_ok_o` rises on the clock edge after the one that brings the count to `dly_ticks_i`. With `dly_ticks_i`=0, it rises on the first edge at which the conditions hold.
- R5: If any condition is lost before qualification, the tick count returns to zero, and the full delay is needed again.
- R6: Deassertion is immediate. `fault_i`=1 at an edge makes `pwr_ok_o` 0 after that edge. A valid sample below the lower level makes it 0 two edges after the sample: one edge to register the level, one to drop the flag.
- R7: With `tune_en_i`=1, ticks are ignored. `pwr_ok_o` rises on the edge at which `tune_done_i`=1 while the conditions hold. A `tune_done_i` pulse while a condition is missing has no effect.
- R8: With `pin_mode_i`=0 (open-drain), good encodes as `pin_oe_o`=0, `pin_dat_o`=0, and not-good encodes as `pin_oe_o`=1, `pin_dat_o`=0.
- R9: With `pin_mode_i`=1 (push-pull), `pin_oe_o`=1 and `pin_dat_o` equals the good state.
- R10: The pin outputs and `pwr_ok_o` are registered from the same next-state value, so they change on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | Voltage sample valid |
| smp_val_i | input | VW | Voltage sample value |
| nom_i | input | VW | Nominal output voltage, same units as the sample |
| rise_pct_i | input | PW | Upper level as a percentage of nominal |
| fall_pct_i | input | PW | Lower level as a percentage of nominal |
| fault_i | input | 1 | A fault is present |
| dly_ticks_i | input | DW | Qualification delay, in ticks |
| tick_i | input | 1 | Slow time-base pulse, one clock wide |
| tune_en_i | input | 1 | Automatic loop tuning is enabled |
| tune_done_i | input | 1 | Loop tuning completed, one clock wide |
| pin_mode_i | input | 1 | 0 = open-drain encoding, 1 = push-pull |
| pwr_ok_o | output | 1 | Power-good status bit |
| pin_dat_o | output | 1 | Flag pin data |
| pin_oe_o | output | 1 | Flag pin output enable |

## Verification
The level assertions assume the configuration has `rise_pct_i` at or above `fall_pct_i`, so that a single sample can never be both above the upper level and below the lower one. The bench sets percentage pairs that keep to this ordering. The bench also keeps `tick_i` and `tune_done_i` to single-cycle pulses, and it changes configuration inputs only while no qualification it is checking is in progress. This way, every expected edge can be counted from the stimulus alone.

// File: rtl/pwrok_pkg.sv
package pwrok_pkg;

  localparam int unsigned PCT_FULL = 100;

  typedef enum logic {
    PIN_OPEN_DRAIN = 1'b0,
    PIN_PUSH_PULL  = 1'b1
  } pin_mode_e;

  typedef struct packed {
    logic dat;
    logic oe;
  } pin_drive_t;

endpackage

// File: rtl/pwrok_level.sv
module pwrok_level
  import pwrok_pkg::*;
#(
  parameter int unsigned VW = 12,
  parameter int unsigned PW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_vld_i,
  input  logic [VW-1:0] smp_val_i,
  input  logic [VW-1:0] nom_i,
  input  logic [PW-1:0] rise_pct_i,
  input  logic [PW-1:0] fall_pct_i,
  output logic          level_ok_o
);

  localparam int unsigned XW = VW + PW;

  logic [XW-1:0] hi_lvl;
  logic [XW-1:0] lo_lvl;
  logic [XW-1:0] smp_x;
  logic          above_hi;
  logic          below_lo;

  always_comb begin
    hi_lvl   = (XW'(nom_i) * XW'(rise_pct_i)) / XW'(PCT_FULL);
    lo_lvl   = (XW'(nom_i) * XW'(fall_pct_i)) / XW'(PCT_FULL);
    smp_x    = XW'(smp_val_i);
    above_hi = smp_x > hi_lvl;
    below_lo = smp_x < lo_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_ok_o <= 1'b0;
    end else if (smp_vld_i) begin
      if (below_lo) begin
        level_ok_o <= 1'b0;
      end else if (above_hi) begin
        level_ok_o <= 1'b1;
      end
    end
  end

  // R3: a valid sample below the lower level clears the level
  p_low_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (smp_vld_i && below_lo) |=> !level_ok_o);

  // R2: a valid sample above the upper level (ordered config) sets it
  p_high_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (smp_vld_i && above_hi && (hi_lvl >= lo_lvl)) |=> level_ok_o);

  // R2/R3: the level does not move without a valid sample
  p_hold_no_vld_r2: assert property (@(posedge clk) disable iff (rst)
    !smp_vld_i |=> $stable(level_ok_o));

endmodule

// File: rtl/pwrok_qual.sv
module pwrok_qual #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cond_i,
  input  logic [DW-1:0] dly_ticks_i,
  input  logic          tick_i,
  input  logic          tune_en_i,
  input  logic          tune_done_i,
  output logic          good_nxt_o,
  output logic          good_o
);

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cnt_nxt;
  logic          cnt_full;

  always_comb begin
    cnt_full   = cnt_q >= dly_ticks_i;
    good_nxt_o = good_o;
    cnt_nxt    = cnt_q;
    if (!cond_i) begin
      good_nxt_o = 1'b0;
      cnt_nxt    = '0;
    end else if (!good_o) begin
      if (tune_en_i) begin
        if (tune_done_i) begin
          good_nxt_o = 1'b1;
        end
      end else if (cnt_full) begin
        good_nxt_o = 1'b1;
      end else if (tick_i) begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      good_o <= 1'b0;
      cnt_q  <= '0;
    end else begin
      good_o <= good_nxt_o;
      cnt_q  <= cnt_nxt;
    end
  end

  // R4: the flag only rises when every condition held at that edge
  p_rise_needs_cond_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(good_o) |-> $past(cond_i));

  // R7: in tuning mode the flag only rises on the completion pulse
  p_tune_bypass_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(good_o) && $past(tune_en_i)) |-> $past(tune_done_i));

  // R5: a lost condition clears the delay count
  p_cnt_clear_r5: assert property (@(posedge clk) disable iff (rst)
    !cond_i |=> (cnt_q == '0) && !good_o);

endmodule

// File: rtl/pwrok_pin.sv
module pwrok_pin
  import pwrok_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic good_nxt_i,
  input  logic pin_mode_i,
  output logic pin_dat_o,
  output logic pin_oe_o
);

  pin_drive_t drv_nxt;

  always_comb begin
    if (pin_mode_e'(pin_mode_i) == PIN_PUSH_PULL) begin
      drv_nxt.dat = good_nxt_i;
      drv_nxt.oe  = 1'b1;
    end else begin
      drv_nxt.dat = 1'b0;
      drv_nxt.oe  = !good_nxt_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_dat_o <= 1'b0;
      pin_oe_o  <= 1'b1;
    end else begin
      pin_dat_o <= drv_nxt.dat;
      pin_oe_o  <= drv_nxt.oe;
    end
  end

  // R8: open-drain encoding never drives the pin high
  p_od_no_high_r8: assert property (@(posedge clk) disable iff (rst)
    !pin_mode_i |=> !pin_dat_o);

endmodule

// File: rtl/pwrok_supervisor.sv
module pwrok_supervisor #(
  parameter int unsigned VW = 12,
  parameter int unsigned PW = 7,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_vld_i,
  input  logic [VW-1:0] smp_val_i,
  input  logic [VW-1:0] nom_i,
  input  logic [PW-1:0] rise_pct_i,
  input  logic [PW-1:0] fall_pct_i,
  input  logic          fault_i,
  input  logic [DW-1:0] dly_ticks_i,
  input  logic          tick_i,
  input  logic          tune_en_i,
  input  logic          tune_done_i,
  input  logic          pin_mode_i,
  output logic          pwr_ok_o,
  output logic          pin_dat_o,
  output logic          pin_oe_o
);

  logic level_ok;
  logic cond_all;
  logic good_nxt;

  pwrok_level #(.VW(VW), .PW(PW)) u_level (
    .clk        (clk),
    .rst        (rst),
    .smp_vld_i  (smp_vld_i),
    .smp_val_i  (smp_val_i),
    .nom_i      (nom_i),
    .rise_pct_i (rise_pct_i),
    .fall_pct_i (fall_pct_i),
    .level_ok_o (level_ok)
  );

  assign cond_all = level_ok && !fault_i;

  pwrok_qual #(.DW(DW)) u_qual (
    .clk         (clk),
    .rst         (rst),
    .cond_i      (cond_all),
    .dly_ticks_i (dly_ticks_i),
    .tick_i      (tick_i),
    .tune_en_i   (tune_en_i),
    .tune_done_i (tune_done_i),
    .good_nxt_o  (good_nxt),
    .good_o      (pwr_ok_o)
  );

  pwrok_pin u_pin (
    .clk        (clk),
    .rst        (rst),
    .good_nxt_i (good_nxt),
    .pin_mode_i (pin_mode_i),
    .pin_dat_o  (pin_dat_o),
    .pin_oe_o   (pin_oe_o)
  );

  // R6: a fault drops the flag on the next edge
  p_fault_drop_r6: assert property (@(posedge clk) disable iff (rst)
    fault_i |=> !pwr_ok_o);

  // R8/R10: open-drain pin tracks the status bit on the same edge
  p_od_encode_r8: assert property (@(posedge clk) disable iff (rst)
    !pin_mode_i |=> (pin_oe_o == !pwr_ok_o) && !pin_dat_o);

  // R9/R10: push-pull pin copies the status bit on the same edge
  p_pp_encode_r9: assert property (@(posedge clk) disable iff (rst)
    pin_mode_i |=> pin_oe_o && (pin_dat_o == pwr_ok_o));

endmodule

// File: tb/test_pwrok_supervisor.sv
module test_pwrok_supervisor;

  localparam int VW = 12;
  localparam int PW = 7;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_vld = 1'b0;
  logic [VW-1:0] smp_val = '0;
  logic [VW-1:0] nom = 12'd1000;
  logic [PW-1:0] rise_pct = 7'd90;
  logic [PW-1:0] fall_pct = 7'd85;
  logic          fault = 1'b0;
  logic [DW-1:0] dly = 16'd3;
  logic          tick = 1'b0;
  logic          tune_en = 1'b0;
  logic          tune_done = 1'b0;
  logic          pin_mode = 1'b0;
  logic          pwr_ok, pin_dat, pin_oe;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  pwrok_supervisor #(.VW(VW), .PW(PW), .DW(DW)) i_pwrok_supervisor (
    .clk(clk), .rst(rst), .smp_vld_i(smp_vld), .smp_val_i(smp_val),
    .nom_i(nom), .rise_pct_i(rise_pct), .fall_pct_i(fall_pct),
    .fault_i(fault), .dly_ticks_i(dly), .tick_i(tick),
    .tune_en_i(tune_en), .tune_done_i(tune_done), .pin_mode_i(pin_mode),
    .pwr_ok_o(pwr_ok), .pin_dat_o(pin_dat), .pin_oe_o(pin_oe)
  );

  // monitor: pops one expected item per falling edge and compares
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if ({pwr_ok, pin_dat, pin_oe} !== e) begin
        n_fail++;
        $display("FAIL %s: ok/dat/oe actual %b%b%b expected %b", t,
                 pwr_ok, pin_dat, pin_oe, e);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input logic ok, input logic dat, input logic oe,
                     input string tag);
    exp_q.push_back({ok, dat, oe});
    tag_q.push_back(tag);
    @(negedge clk);
    #1;
  endtask

  task automatic sample(input logic [VW-1:0] v);
    smp_val = v;
    smp_vld = 1'b1;
    step(1);
    smp_vld = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      tick = 1'b1;
      step(1);
      tick = 1'b0;
    end
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    chk(0, 0, 1, "R1 reset state");

    sample(950);
    ticks(3);
    chk(0, 0, 1, "R4 still waiting at count edge");
    step(1);
    chk(1, 0, 0, "R4 R8 R10 asserted after delay, open-drain released");

    sample(870);
    step(2);
    chk(1, 0, 0, "R3 between levels holds good");
    smp_val = 100;
    step(3);
    chk(1, 0, 0, "R2 R3 invalid sample ignored");

    sample(849);
    step(1);
    chk(0, 0, 1, "R6 drop two edges after low sample");

    sample(880);
    ticks(5);
    step(1);
    chk(0, 0, 1, "R3 between levels holds bad");
    sample(900);
    ticks(5);
    step(1);
    chk(0, 0, 1, "R2 equal to upper level does not raise");
    sample(901);
    ticks(3);
    step(1);
    chk(1, 0, 0, "R2 strictly above upper level");

    fault = 1'b1;
    step(1);
    chk(0, 0, 1, "R6 fault drops at once");
    fault = 1'b0;
    ticks(2);
    fault = 1'b1;
    step(1);
    fault = 1'b0;
    ticks(2);
    chk(0, 0, 1, "R5 count restarted after lost condition");
    ticks(1);
    step(1);
    chk(1, 0, 0, "R5 full delay after restart");

    pin_mode = 1'b1;
    step(1);
    chk(1, 1, 1, "R9 push-pull good");
    fault = 1'b1;
    step(1);
    chk(0, 0, 1, "R9 R6 push-pull not good");
    fault = 1'b0;
    dly = 16'd0;
    step(1);
    chk(1, 1, 1, "R4 zero delay asserts next edge");

    pin_mode = 1'b0;
    dly = 16'd3;
    tune_en = 1'b1;
    fault = 1'b1;
    step(1);
    fault = 1'b0;
    ticks(6);
    step(1);
    chk(0, 0, 1, "R7 ticks ignored in tuning mode");
    tune_done = 1'b1;
    step(1);
    tune_done = 1'b0;
    chk(1, 0, 0, "R7 asserted on tuning done");
    fault = 1'b1;
    tune_done = 1'b1;
    step(1);
    tune_done = 1'b0;
    fault = 1'b0;
    ticks(4);
    step(1);
    chk(0, 0, 1, "R7 done pulse while faulted ignored");
    tune_en = 1'b0;
    ticks(3);
    step(1);
    chk(1, 0, 0, "R4 normal delay after leaving tuning mode");

    rise_pct = 7'd50;
    fall_pct = 7'd40;
    sample(300);
    step(1);
    chk(0, 0, 1, "R3 configured lower level");
    sample(450);
    ticks(4);
    step(1);
    chk(0, 0, 1, "R2 configured between levels");
    sample(510);
    ticks(3);
    step(1);
    chk(1, 0, 0, "R2 configured upper level");
    sample(399);
    step(1);
    chk(0, 0, 1, "R6 configured drop");

    step(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule